// File: doc/BRIEF.md
# LIN Serial Receiver with Break Detection

This block is the receive half of a LIN-capable serial port. A 16x oversampling enable paces it. It confirms a start bit at mid-bit, shifts in eight data bits least significant bit first, and checks the first stop bit. Good frames go into a one-byte holding register, and a data-full flag is raised. A frame whose stop bit reads low sets a framing-error flag. A good frame that arrives while the previous byte is still unread sets an overrun flag.

Alongside the framer, a separate counter measures how long the input stays low. Once the line has been low for eleven bit times, a break flag is raised. A break always ends in a failed stop bit, so it also sets the framing-error flag. The all-zero byte it produces is dropped. After any failed stop bit, the receiver waits for the line to go high again before it looks for a new start bit.

Software reaches the block through strobes. A read strobe consumes the byte. A write strobe carries two values. One is a clear-errors value: a 1 clears both error flags. The other is a keep-break value: a 0 clears the break flag. A single interrupt output combines the receive and break conditions under their two enables.

Top module: `lin_rx_core`

## Requirements
- R1: A frame (low start bit, 8 data bits LSB first, high stop bit) loads its byte into `rx_data` and sets `data_full`.
- R2: A low pulse that is gone before the mid-bit sample, 8 ticks after the falling edge, starts no frame: no flag changes.
- R3: A pulse on `rd_strobe` clears `data_full`.
- R4: A frame whose first stop bit is low sets `frame_err`. Its byte is not loaded, and `data_full` does not change.
- R5: A good frame that completes while `data_full` is 1 sets `overrun_err`. `rx_data` keeps the unread byte.
- R6: A write with `wr_err_clr`=1 clears both `frame_err` and `overrun_err`. A write with `wr_err_clr`=0 leaves them unchanged.
- R7: `brk_flag` sets once the input has been low for 11 bit times (176 ticks). It is still 0 after 10.5 bit times low.
- R8: A write with `wr_brk_keep`=0 clears `brk_flag`. A write with `wr_brk_keep`=1 leaves it set.
- R9: `irq` is 1 when `rx_irq_en` is set and any of `data_full`, `frame_err` or `overrun_err` is 1, or when `brk_irq_en` and `brk_flag` are both 1. Otherwise it is 0.
- R10: After a failed stop bit, start detection resumes only once the input has returned high. The first frame after a break is received correctly.
- R11: After reset, all flags, `irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable, one cycle wide |
| rx_in | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Read of the data register |
| wr_strobe | input | 1 | Write of the status controls |
| wr_err_clr | input | 1 | With a write: 1 clears both error flags |
| wr_brk_keep | input | 1 | With a write: 0 clears the break flag |
| rx_irq_en | input | 1 | Receive interrupt enable |
| brk_irq_en | input | 1 | Break interrupt enable |
| rx_data | output | 8 | Received byte |
| data_full | output | 1 | Unread byte held |
| frame_err | output | 1 | Framing error flag |
| overrun_err | output | 1 | Overrun error flag |
| brk_flag | output | 1 | Break detected flag |
| irq | output | 1 | Receive/status interrupt request |

## Verification
The bench holds the line low for exactly 10.5 and then 11.5 bit times. This pins the break threshold: a counter that is off by a bit, or that follows a length setting, fails one of the two samples. A short glitch exposes a receiver that accepts a start bit on the edge alone, because that receiver would report a frame or a framing error. The bench sends a second byte without reading the first. A design that overwrites the held byte shows the wrong `rx_data`. Its write-value polarities catch clear controls that are inverted. A byte sent right after a long break catches a receiver that re-arms while the line is still low: it would lose alignment and mis-receive that byte.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lin_rx_framer.sv
module lin_rx_framer
    import lin_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    output logic                 done,
    output logic                 stop_ok,
    output logic [DATA_BITS-1:0] data
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] sh;
    } fr_t;

    fr_t q, d;
    logic done_d, stop_ok_d;

    always_comb begin
        d         = q;
        done_d    = 1'b0;
        stop_ok_d = 1'b0;
        if (tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        d.cnt  = '0;
                        d.bidx = '0;
                        d.st   = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt = '0;
                        d.sh  = {rx, q.sh[DATA_BITS-1:1]};
                        if (q.bidx == BW'(DATA_BITS - 1)) d.st = ST_STOP;
                        else                              d.bidx = q.bidx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt     = '0;
                        done_d    = 1'b1;
                        stop_ok_d = rx;
                        d.st      = rx ? ST_IDLE : ST_WAITHI;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WAITHI: begin
                    if (rx) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '{st: ST_IDLE, cnt: '0, bidx: '0, sh: '0};
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            q       <= d;
            done    <= done_d;
            stop_ok <= stop_ok_d;
        end
    end

    assign data = q.sh;

    // R2: a start that is high again at mid-bit falls back to idle
    assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.st == ST_START && q.cnt == CW'(HALF - 1) && rx) |=> (q.st == ST_IDLE));

    // R10: leaving the wait state requires a high line
    assert_rearm_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAITHI && !rx) |=> (q.st == ST_WAITHI));

    // R4: a low stop always parks the framer until the line is high
    assert_bad_stop_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stop_ok) |-> (q.st == ST_WAITHI || $past(rx)));
endmodule

// File: rtl/lin_rx_brk.sv
module lin_rx_brk #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic hit
);
    localparam int LIMIT = OVS * BRK_BITS;
    localparam int LW    = $clog2(LIMIT + 1);

    logic [LW-1:0] cnt_d, cnt_q;
    logic          hit_d;

    always_comb begin
        cnt_d = cnt_q;
        hit_d = 1'b0;
        if (tick) begin
            if (rx) begin
                cnt_d = '0;
            end else if (cnt_q != LW'(LIMIT)) begin
                cnt_d = cnt_q + 1'b1;
                hit_d = (cnt_q == LW'(LIMIT - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            hit   <= hit_d;
        end
    end

    // R7: the detector only fires after a low tick
    assert_hit_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(!rx));

    // R7: one hit per low period
    assert_hit_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/lin_rx_regs.sv
module lin_rx_regs #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic                 stop_ok,
    input  logic [DATA_BITS-1:0] fr_data,
    input  logic                 brk_hit,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 wr_clr,
    input  logic                 wr_keep,
    input  logic                 rie,
    input  logic                 bie,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 full,
    output logic                 fe,
    output logic                 ore,
    output logic                 brk,
    output logic                 irq
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 fe;
        logic                 ore;
        logic                 brk;
    } rg_t;

    rg_t q, d;

    always_comb begin
        d = q;
        if (rd) d.full = 1'b0;
        if (wr && wr_clr) begin
            d.fe  = 1'b0;
            d.ore = 1'b0;
        end
        if (wr && !wr_keep) d.brk = 1'b0;
        if (done) begin
            if (!stop_ok) begin
                d.fe = 1'b1;
            end else if (q.full && !rd) begin
                d.ore = 1'b1;
            end else begin
                d.data = fr_data;
                d.full = 1'b1;
            end
        end
        if (brk_hit) d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.data;
    assign full    = q.full;
    assign fe      = q.fe;
    assign ore     = q.ore;
    assign brk     = q.brk;
    assign irq     = (rie && (q.full || q.fe || q.ore)) || (bie && q.brk);

    // R1: full rises only after a good frame from the framer
    assert_full_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> $past(done && stop_ok));

    // R3: a read without a new frame empties the register
    assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !q.full);

    // R5: an overrun keeps the unread byte
    assert_ovr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stop_ok && q.full && !rd) |=> ($stable(q.data) && q.ore));

    // R6: a clear write without a frame empties both error flags
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_clr && !done) |=> (!q.fe && !q.ore));

    // R8: the break flag rises only on a detector hit
    assert_brk_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.brk) |-> $past(brk_hit));

    // R9: an enabled break always requests an interrupt
    assert_brk_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bie && q.brk) |-> irq);
endmodule

// File: rtl/lin_rx_core.sv
module lin_rx_core #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int BRK_BITS    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rx_in,
    input  logic                 rd_strobe,
    input  logic                 wr_strobe,
    input  logic                 wr_err_clr,
    input  logic                 wr_brk_keep,
    input  logic                 rx_irq_en,
    input  logic                 brk_irq_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_full,
    output logic                 frame_err,
    output logic                 overrun_err,
    output logic                 brk_flag,
    output logic                 irq
);
    logic                 rx_s;
    logic                 fr_done, fr_stop_ok, brk_hit;
    logic [DATA_BITS-1:0] fr_data;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    lin_rx_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .done(fr_done), .stop_ok(fr_stop_ok), .data(fr_data)
    );

    lin_rx_brk #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .hit(brk_hit)
    );

    lin_rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .done(fr_done), .stop_ok(fr_stop_ok),
        .fr_data(fr_data), .brk_hit(brk_hit), .rd(rd_strobe), .wr(wr_strobe),
        .wr_clr(wr_err_clr), .wr_keep(wr_brk_keep), .rie(rx_irq_en),
        .bie(brk_irq_en), .rx_data(rx_data), .full(data_full), .fe(frame_err),
        .ore(overrun_err), .brk(brk_flag), .irq(irq)
    );

    // R11: outputs are quiet in the first cycle after reset release
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (!data_full && !frame_err && !overrun_err && !brk_flag));
endmodule

// File: tb/tb_lin_rx_core.sv
module tb_lin_rx_core;
    localparam int BITC = 32; // 16 ticks, one tick every 2 cycles

    logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_in = 1'b1;
    logic rd_strobe = 1'b0, wr_strobe = 1'b0, wr_err_clr = 1'b0, wr_brk_keep = 1'b1;
    logic rx_irq_en = 1'b0, brk_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic data_full, frame_err, overrun_err, brk_flag, irq;

    int total = 0, bad = 0;
    bit auto_rd = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    lin_rx_core dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stp);
        if (auto_rd && stp) exp_q.push_back(b);
        rx_in = 1'b0; idle(BITC);
        for (int i = 0; i < 8; i++) begin rx_in = b[i]; idle(BITC); end
        rx_in = stp; idle(BITC);
        rx_in = 1'b1; idle(BITC);
    endtask

    task automatic reg_wr(input logic clr, input logic keep);
        wr_err_clr = clr; wr_brk_keep = keep; wr_strobe = 1'b1;
        idle(1);
        wr_strobe = 1'b0; wr_err_clr = 1'b0; wr_brk_keep = 1'b1;
        idle(2);
    endtask

    // scoreboard monitor: R1 and R3
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && data_full) begin
                if (exp_q.size() == 0) chk("R1 unexpected byte", {24'h0, rx_data}, 32'hx);
                else chk("R1 byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
                @(negedge clk);
                chk("R3 read clears full", data_full, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5); rst_n = 1'b1; idle(3);
        chk("R11 full", data_full, 0);     chk("R11 fe", frame_err, 0);
        chk("R11 ore", overrun_err, 0);    chk("R11 brk", brk_flag, 0);
        chk("R11 irq", irq, 0);            chk("R11 data", {24'h0, rx_data}, 0);

        auto_rd = 1'b1;
        send(8'hA5, 1'b1); send(8'h3C, 1'b1); send(8'h01, 1'b1); send(8'hFF, 1'b1);
        idle(4);
        chk("R1 queue drained", exp_q.size(), 0);
        auto_rd = 1'b0;

        // R2: glitch of 3 ticks
        rx_in = 1'b0; idle(6); rx_in = 1'b1; idle(12 * BITC);
        chk("R2 no frame full", data_full, 0);
        chk("R2 no frame fe", frame_err, 0);

        // R9, R5, R3
        rx_irq_en = 1'b1;
        send(8'h5A, 1'b1);
        chk("R1 held full", data_full, 1);
        chk("R1 held data", {24'h0, rx_data}, 32'h5A);
        chk("R9 irq on full", irq, 1);
        send(8'h77, 1'b1);
        chk("R5 overrun", overrun_err, 1);
        chk("R5 data kept", {24'h0, rx_data}, 32'h5A);
        rd_strobe = 1'b1; idle(1); rd_strobe = 1'b0; idle(1);
        chk("R3 read clears", data_full, 0);
        reg_wr(1'b0, 1'b1);
        chk("R6 write zero keeps ore", overrun_err, 1);
        reg_wr(1'b1, 1'b1);
        chk("R6 clear ore", overrun_err, 0);
        chk("R9 irq idle", irq, 0);

        // R4
        send(8'h33, 1'b0);
        chk("R4 fe set", frame_err, 1);
        chk("R4 no load", data_full, 0);
        chk("R4 data unchanged", {24'h0, rx_data}, 32'h5A);
        reg_wr(1'b1, 1'b1);
        chk("R6 clear fe", frame_err, 0);

        // R7 break
        rx_irq_en = 1'b0; brk_irq_en = 1'b1;
        rx_in = 1'b0; idle(BITC * 21 / 2);
        chk("R7 no break at 10.5 bits", brk_flag, 0);
        chk("R4 break framing", frame_err, 1);
        idle(BITC);
        chk("R7 break at 11.5 bits", brk_flag, 1);
        chk("R9 break irq", irq, 1);
        chk("R4 break byte dropped", data_full, 0);
        idle(BITC * 3 / 2);
        rx_in = 1'b1; idle(BITC);
        reg_wr(1'b0, 1'b1);
        chk("R8 write one keeps brk", brk_flag, 1);
        reg_wr(1'b0, 1'b0);
        chk("R8 write zero clears brk", brk_flag, 0);
        chk("R9 irq gated by enable", irq, 0);
        reg_wr(1'b1, 1'b1);

        // R10: first frame after break
        auto_rd = 1'b1;
        send(8'h96, 1'b1);
        idle(4);
        chk("R10 byte after break", exp_q.size(), 0);
        chk("R10 no error", frame_err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule